// File: doc/BRIEF.md
# Chunked Cartridge-to-DRAM Copy Sequencer

This block copies a run of bytes from a cartridge-side byte source into DRAM. A single start pulse supplies a DRAM address, a cartridge address and a length field. The transfer is then split into chunks of at most 128 bytes. For each chunk the engine fetches bytes from the cartridge port into a local buffer, one byte per clock. It then drains the buffer into the DRAM port, again one byte per clock. Both ports use big-endian byte-lane swizzling.

Between chunks both pointers advance. The cartridge pointer steps by the even read count. The DRAM pointer is pushed up to the next 8-byte boundary. The first chunk gets its own length correction, which depends on where the DRAM address falls inside an 8-byte word.

On completion the block raises a one-cycle done pulse. It also presents the final DRAM pointer, the final cartridge pointer and a rewritten length value that a register file next to it can load.

Top module: `cart_chunk_dma`

## Requirements
- R1: A transfer moves length field + 1 bytes in total, counted from the uncorrected chunk lengths. The engine keeps producing chunks until that count is used up, and then finishes.
- R2: A chunk's capacity is 128 minus (DRAM pointer AND 6). Its length is the smaller of that capacity and the bytes still remaining.
- R3: Each chunk reads the chunk length rounded up to an even number of cartridge bytes. The cartridge pointer advances by that rounded count, and cart_addr_out shows the final pointer.
- R4: On the first chunk only, a chunk length equal to capacity minus 1 is raised by one. The alignment offset (DRAM pointer AND 6) is then subtracted from the first chunk's write count, with a floor of zero.
- R5: After each chunk the DRAM pointer advances by the chunk's write count and is then rounded up to a multiple of 8. dram_addr_out shows the final pointer.
- R6: len_out is loaded at start. It becomes 0x7F minus (dram_addr_in AND 7) when length field + 1 is at most 8, and 0x7F otherwise.
- R7: Byte i of a chunk is read from cartridge address (cartridge pointer + i) XOR 3. Buffer byte i is written to DRAM address (DRAM pointer + i) XOR 3.
- R8: A cartridge byte address at or above image_size yields zero, and no read strobe is issued for it.
- R9: The starting DRAM pointer keeps only bits 22..1 of dram_addr_in. Bit 0 and bit 23 are dropped.
- R10: busy is high from the cycle after an accepted start pulse through the one-cycle done pulse. A start pulse that arrives while busy is ignored. The cartridge strobe and the DRAM strobe are never active in the same cycle.
- R11: After reset, busy, done and both strobes are low, and len_out reads 0x7F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a transfer |
| dram_addr_in | input | 24 | DRAM byte address for the transfer |
| cart_addr_in | input | 32 | Cartridge byte address for the transfer |
| len_in | input | 24 | Length field (byte count minus one) |
| image_size | input | 32 | Cartridge image size in bytes |
| cart_rd_en | output | 1 | Cartridge byte read strobe |
| cart_rd_addr | output | 32 | Swizzled cartridge byte address |
| cart_rd_data | input | 8 | Cartridge byte, valid in the same cycle as the address |
| dram_wr_en | output | 1 | DRAM byte write strobe |
| dram_wr_addr | output | 23 | Swizzled DRAM byte address |
| dram_wr_data | output | 8 | DRAM byte to write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| dram_addr_out | output | 23 | DRAM pointer after the last chunk |
| cart_addr_out | output | 32 | Cartridge pointer after the last chunk |
| len_out | output | 24 | Rewritten length value |

## Verification
The hardest case to reach from the ports is the first-chunk correction. In that case the chunk length lands exactly one below capacity and an alignment offset is subtracted afterwards. The offset can be large enough to leave zero bytes to write, or the length can be bumped up before it is trimmed. The stimulus reaches these cases by choosing DRAM addresses with low bits 2, 4 and 6, together with byte counts of capacity minus one and very short counts. Other vectors place the image end inside a later chunk, so the zero fill and the missing read strobes show up at a chunk boundary. One start pulse is sent while a transfer is running, and the bench confirms that it leaves the result unchanged.

// File: rtl/cart_dma_pkg.sv
// Shared types and helpers for the chunked cartridge-to-DRAM sequencer.
// Assumes byte-wide ports and big-endian lane order inside 32-bit words.
package cart_dma_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_SIZE,
        SEQ_FETCH,
        SEQ_STORE,
        SEQ_ADV,
        SEQ_FIN
    } seq_state_t;

    // Length value that the block loads into len_out when it comes out of reset.
    localparam logic [7:0] LEN_RESET = 8'h7F;

endpackage

// File: rtl/cart_chunk_size.sv
// Chunk sizing: works out the read count, write count and leftover byte
// count of the next chunk from the DRAM alignment, the bytes remaining and
// the first-chunk flag. Purely combinational. Assumes remaining > 0.
module cart_chunk_size #(
    parameter int BUF_BYTES = 128,
    parameter int LEN_W     = 24,
    localparam int CNT_W    = $clog2(BUF_BYTES) + 1
) (
    input  logic [1:0]       align_sel,
    input  logic [LEN_W:0]   remaining,
    input  logic             first,
    output logic [CNT_W-1:0] rd_len,
    output logic [CNT_W-1:0] wr_len,
    output logic [LEN_W:0]   rem_next
);

    logic [CNT_W-1:0] align;
    logic [CNT_W-1:0] cap;
    logic [CNT_W-1:0] take;
    logic [CNT_W-1:0] adj;

    // Capacity, chunk length, even read count and first-chunk correction.
    always_comb begin
        align = {{(CNT_W-3){1'b0}}, align_sel, 1'b0};
        cap   = CNT_W'(BUF_BYTES) - align;
        if (remaining >= (LEN_W+1)'(cap)) take = cap;
        else                              take = remaining[CNT_W-1:0];
        rd_len = take + {{(CNT_W-1){1'b0}}, take[0]};
        adj    = (first && (take == cap - 1'b1)) ? take + 1'b1 : take;
        if (first) wr_len = (adj > align) ? adj - align : '0;
        else       wr_len = take;
        rem_next = remaining - (LEN_W+1)'(take);
    end

    // The buffer never holds fewer bytes than are written out (R4).
    always_comb begin
        p_write_within_read_r4 : assert (wr_len <= rd_len);
    end

endmodule

// File: rtl/cart_read_port.sv
// Cartridge-side address generation: swaps byte lanes, blocks reads past the
// image end and forces those bytes to zero. Combinational. Assumes the
// cartridge source answers in the same cycle as the address.
module cart_read_port #(
    parameter int CART_AW = 32,
    parameter int CNT_W   = 8
) (
    input  logic               active,
    input  logic [CART_AW-1:0] base,
    input  logic [CNT_W-1:0]   idx,
    input  logic [CART_AW-1:0] image_size,
    input  logic [7:0]         rd_data,
    output logic               rd_en,
    output logic [CART_AW-1:0] rd_addr,
    output logic [7:0]         byte_out
);

    logic in_range;

    // Lane-swapped address, range check and zero substitution.
    always_comb begin
        rd_addr  = (base + CART_AW'(idx)) ^ CART_AW'(3);
        in_range = rd_addr < image_size;
        rd_en    = active && in_range;
        byte_out = in_range ? rd_data : 8'h00;
    end

endmodule

// File: rtl/cart_chunk_buf.sv
// Chunk staging buffer: one byte write port, one combinational read port.
// Holds no reset, because every byte is written before it is read.
module cart_chunk_buf #(
    parameter int BUF_BYTES = 128,
    localparam int IDX_W    = $clog2(BUF_BYTES)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data
);

    logic [7:0] mem [BUF_BYTES];

    // Store one fetched byte.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    // Present the byte being drained.
    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/cart_chunk_dma.sv
// Chunked cartridge-to-DRAM copy sequencer. On start it latches the
// pointers and the byte count. For each chunk it sizes the chunk, fetches
// the bytes into the buffer, drains them to DRAM and steps both pointers.
// When the count is used up it pulses done.
// Assumes start is ignored while busy and that the cartridge source answers
// in the same cycle as the address.
module cart_chunk_dma
    import cart_dma_pkg::*;
#(
    parameter int BUF_BYTES = 128,
    parameter int DRAM_AW   = 23,
    parameter int DRAM_IN_W = DRAM_AW + 1,
    parameter int CART_AW   = 32,
    parameter int LEN_W     = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [DRAM_IN_W-1:0] dram_addr_in,
    input  logic [CART_AW-1:0]   cart_addr_in,
    input  logic [LEN_W-1:0]     len_in,
    input  logic [CART_AW-1:0]   image_size,
    output logic                 cart_rd_en,
    output logic [CART_AW-1:0]   cart_rd_addr,
    input  logic [7:0]           cart_rd_data,
    output logic                 dram_wr_en,
    output logic [DRAM_AW-1:0]   dram_wr_addr,
    output logic [7:0]           dram_wr_data,
    output logic                 busy,
    output logic                 done,
    output logic [DRAM_AW-1:0]   dram_addr_out,
    output logic [CART_AW-1:0]   cart_addr_out,
    output logic [LEN_W-1:0]     len_out
);

    localparam int CNT_W = $clog2(BUF_BYTES) + 1;
    localparam int IDX_W = $clog2(BUF_BYTES);

    seq_state_t          state;
    logic [DRAM_AW-1:0]  dram_ptr;
    logic [CART_AW-1:0]  cart_ptr;
    logic [LEN_W:0]      remaining;
    logic                first;
    logic [CNT_W-1:0]    idx;
    logic [CNT_W-1:0]    rd_len;
    logic [CNT_W-1:0]    wr_len;

    logic [CNT_W-1:0]    calc_rd;
    logic [CNT_W-1:0]    calc_wr;
    logic [LEN_W:0]      calc_rem;
    logic [7:0]          fetched;
    logic [7:0]          buf_q;
    logic [DRAM_AW-1:0]  ptr_step;
    logic [LEN_W:0]      total;
    logic [LEN_W-1:0]    len_rewrite;
    logic                unused_addr_hi;

    assign unused_addr_hi = ^dram_addr_in[DRAM_IN_W-1:DRAM_AW];

    cart_chunk_size #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) u_size (
        .align_sel (dram_ptr[2:1]),
        .remaining (remaining),
        .first     (first),
        .rd_len    (calc_rd),
        .wr_len    (calc_wr),
        .rem_next  (calc_rem)
    );

    cart_read_port #(.CART_AW(CART_AW), .CNT_W(CNT_W)) u_rdport (
        .active     (state == SEQ_FETCH),
        .base       (cart_ptr),
        .idx        (idx),
        .image_size (image_size),
        .rd_data    (cart_rd_data),
        .rd_en      (cart_rd_en),
        .rd_addr    (cart_rd_addr),
        .byte_out   (fetched)
    );

    cart_chunk_buf #(.BUF_BYTES(BUF_BYTES)) u_buf (
        .clk     (clk),
        .wr_en   (state == SEQ_FETCH),
        .wr_idx  (idx[IDX_W-1:0]),
        .wr_data (fetched),
        .rd_idx  (idx[IDX_W-1:0]),
        .rd_data (buf_q)
    );

    // Length rewrite value from the start request.
    always_comb begin
        total = {1'b0, len_in} + 1'b1;
        if (total <= (LEN_W+1)'(8))
            len_rewrite = LEN_W'(LEN_RESET) - LEN_W'(dram_addr_in[2:0]);
        else
            len_rewrite = LEN_W'(LEN_RESET);
    end

    // DRAM pointer after the current chunk, before rounding to 8 bytes.
    assign ptr_step = dram_ptr + DRAM_AW'(wr_len) + DRAM_AW'(7);

    // DRAM-side strobe, swizzled address and data.
    always_comb begin
        dram_wr_en   = (state == SEQ_STORE);
        dram_wr_addr = (dram_ptr + DRAM_AW'(idx)) ^ DRAM_AW'(3);
        dram_wr_data = buf_q;
    end

    // Sequencer: sizing, fetch phase, store phase, pointer advance, done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SEQ_IDLE;
            dram_ptr  <= '0;
            cart_ptr  <= '0;
            remaining <= '0;
            first     <= 1'b0;
            idx       <= '0;
            rd_len    <= '0;
            wr_len    <= '0;
            len_out   <= LEN_W'(LEN_RESET);
        end else begin
            case (state)
                SEQ_IDLE: if (start) begin
                    dram_ptr  <= {dram_addr_in[DRAM_AW-1:1], 1'b0};
                    cart_ptr  <= cart_addr_in;
                    remaining <= {1'b0, len_in} + 1'b1;
                    first     <= 1'b1;
                    len_out   <= len_rewrite;
                    state     <= SEQ_SIZE;
                end
                SEQ_SIZE: begin
                    rd_len    <= calc_rd;
                    wr_len    <= calc_wr;
                    remaining <= calc_rem;
                    idx       <= '0;
                    state     <= SEQ_FETCH;
                end
                SEQ_FETCH: begin
                    if (idx == rd_len - 1'b1) begin
                        cart_ptr <= cart_ptr + CART_AW'(rd_len);
                        idx      <= '0;
                        state    <= (wr_len == '0) ? SEQ_ADV : SEQ_STORE;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                SEQ_STORE: begin
                    if (idx == wr_len - 1'b1) state <= SEQ_ADV;
                    else                      idx   <= idx + 1'b1;
                end
                SEQ_ADV: begin
                    dram_ptr <= {ptr_step[DRAM_AW-1:3], 3'b000};
                    first    <= 1'b0;
                    state    <= (remaining == '0) ? SEQ_FIN : SEQ_SIZE;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    assign busy          = (state != SEQ_IDLE);
    assign done          = (state == SEQ_FIN);
    assign dram_addr_out = dram_ptr;
    assign cart_addr_out = cart_ptr;

    // The completion pulse lasts exactly one cycle (R10).
    p_done_single_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Without a start pulse an idle engine stays idle (R10).
    p_idle_holds_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !busy);

    // The two ports are never strobed in the same cycle (R10).
    p_ports_exclusive_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        !(cart_rd_en && dram_wr_en));

    // No cartridge read is issued past the image end (R8).
    p_read_in_image_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        cart_rd_en |-> (cart_rd_addr < image_size));

    // Every chunk after the first starts on an 8-byte DRAM boundary (R5).
    p_realigned_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_SIZE && !first) |-> (dram_ptr[2:0] == 3'b000));

endmodule

// File: tb/cart_chunk_dma_test.sv
module cart_chunk_dma_test;

    localparam int WIN = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] dram_addr_in = '0;
    logic [31:0] cart_addr_in = '0;
    logic [23:0] len_in = '0;
    logic [31:0] image_size = '0;
    logic        cart_rd_en;
    logic [31:0] cart_rd_addr;
    logic [7:0]  cart_rd_data;
    logic        dram_wr_en;
    logic [22:0] dram_wr_addr;
    logic [7:0]  dram_wr_data;
    logic        busy, done;
    logic [22:0] dram_addr_out;
    logic [31:0] cart_addr_out;
    logic [23:0] len_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int wr_count = 0;
    int rd_count = 0;
    int oob_count = 0;

    logic [7:0] dmem [WIN];
    logic       dflag [WIN];
    logic [7:0] emem [WIN];
    logic       eflag [WIN];

    always #4 clk = ~clk;

    function automatic logic [7:0] pat(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    assign cart_rd_data = pat(cart_rd_addr);

    cart_chunk_dma uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dram_addr_in(dram_addr_in), .cart_addr_in(cart_addr_in),
        .len_in(len_in), .image_size(image_size),
        .cart_rd_en(cart_rd_en), .cart_rd_addr(cart_rd_addr),
        .cart_rd_data(cart_rd_data),
        .dram_wr_en(dram_wr_en), .dram_wr_addr(dram_wr_addr),
        .dram_wr_data(dram_wr_data),
        .busy(busy), .done(done),
        .dram_addr_out(dram_addr_out), .cart_addr_out(cart_addr_out),
        .len_out(len_out)
    );

    // Port monitor: DRAM writes and cartridge reads.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (dram_wr_en) begin
            wr_count <= wr_count + 1;
            if (dram_wr_addr < 23'(WIN)) begin
                dmem[dram_wr_addr] <= dram_wr_data;
                dflag[dram_wr_addr] <= 1'b1;
            end else begin
                oob_count <= oob_count + 1;
            end
        end
        if (cart_rd_en) begin
            rd_count <= rd_count + 1;
            if (cart_rd_addr >= image_size) oob_count <= oob_count + 1;
        end
    end

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cyc > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: act=%0d cycles exp=<150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    // Expected results built from the requirements.
    int unsigned e_dram, e_cart, e_len, e_reads, e_writes;

    task automatic model(input logic [23:0] d, input logic [31:0] c,
                         input logic [23:0] l, input logic [31:0] isz);
        int unsigned dp, cp, rem, al, cap, bl, rl, tot;
        bit first;
        logic [7:0] blk [128];
        for (int i = 0; i < WIN; i++) begin
            emem[i] = 8'hEE;
            eflag[i] = 1'b0;
        end
        dp = d & 24'h7FFFFE;
        cp = c;
        tot = l + 1;
        rem = tot;
        first = 1'b1;
        e_reads = 0;
        e_writes = 0;
        while (rem > 0) begin
            al = dp & 6;
            cap = 128 - al;
            bl = (rem < cap) ? rem : cap;
            rem = rem - bl;
            rl = (bl + 1) & ~1;
            for (int i = 0; i < int'(rl); i++) begin
                int unsigned a;
                a = (cp + i) ^ 3;
                if (a < isz) begin
                    blk[i] = pat(a);
                    e_reads++;
                end else begin
                    blk[i] = 8'h00;
                end
            end
            cp = cp + rl;
            if (first) begin
                if (bl == cap - 1) bl = bl + 1;
                bl = (bl > al) ? bl - al : 0;
            end
            for (int i = 0; i < int'(bl); i++) begin
                int unsigned wa;
                wa = ((dp + i) ^ 3) & 32'h7FFFFF;
                emem[wa] = blk[i];
                eflag[wa] = 1'b1;
                e_writes++;
            end
            dp = ((dp + bl + 7) & ~7) & 32'h7FFFFF;
            first = 1'b0;
        end
        e_dram = dp;
        e_cart = cp;
        e_len = (tot <= 8) ? (32'h7F - (d & 7)) : 32'h7F;
    endtask

    task automatic clear_ports();
        for (int i = 0; i < WIN; i++) begin
            dmem[i] = 8'hEE;
            dflag[i] = 1'b0;
        end
        wr_count = 0;
        rd_count = 0;
        oob_count = 0;
    endtask

    // Start a transfer, optionally poke start mid-flight, wait for done, compare.
    task automatic run(input logic [23:0] d, input logic [31:0] c,
                       input logic [23:0] l, input logic [31:0] isz,
                       input bit poke);
        int waitc;
        int bad;
        model(d, c, l, isz);
        @(negedge clk);
        clear_ports();
        dram_addr_in = d; cart_addr_in = c; len_in = l; image_size = isz;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R10 busy after start", longint'(busy), 1);
        if (poke) begin
            repeat (3) @(negedge clk);
            dram_addr_in = 24'h000300; cart_addr_in = 32'h99; len_in = 24'd40;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            dram_addr_in = d; cart_addr_in = c; len_in = l;
        end
        waitc = 0;
        while (!done && waitc < 20000) begin
            @(negedge clk);
            waitc++;
        end
        check(done == 1'b1, "R10 done seen", longint'(done), 1);
        check(dram_addr_out == 23'(e_dram), "R5 final DRAM pointer", longint'(dram_addr_out), longint'(e_dram));
        check(cart_addr_out == e_cart, "R3 final cartridge pointer", longint'(cart_addr_out), longint'(e_cart));
        check(len_out == 24'(e_len), "R6 rewritten length", longint'(len_out), longint'(e_len));
        @(negedge clk);
        check(!done && !busy, "R10 done one cycle then idle", longint'({done, busy}), 0);
        check(wr_count == int'(e_writes), "R1 R2 R4 write count", longint'(wr_count), longint'(e_writes));
        check(rd_count == int'(e_reads), "R3 R8 read count", longint'(rd_count), longint'(e_reads));
        check(oob_count == 0, "R8 R9 accesses out of range", longint'(oob_count), 0);
        bad = 0;
        for (int i = 0; i < WIN; i++) begin
            if (dmem[i] !== emem[i] || dflag[i] !== eflag[i]) begin
                if (bad == 0)
                    $display("FAIL R7 DRAM byte 0x%0h: act=0x%0h exp=0x%0h", i, dmem[i], emem[i]);
                bad++;
            end
        end
        check(bad == 0, "R7 DRAM image", longint'(bad), 0);
    endtask

    // Vectors: dram address, cartridge address, length field, image size.
    localparam logic [111:0] VEC [7] = '{
        {24'h000000, 32'h00000100, 24'd15,  32'h00010000},  // plain aligned, R1
        {24'h000002, 32'h00000040, 24'd200, 32'h00010000},  // multi-chunk, R2 R4
        {24'h000006, 32'h00000011, 24'd3,   32'h00010000},  // R4 floor to zero, R6
        {24'h000010, 32'h00000000, 24'd300, 32'h00000080},  // R8 zero fill
        {24'h800005, 32'h00000020, 24'd6,   32'h00010000},  // R9 mask, R6
        {24'h000004, 32'h00000008, 24'd122, 32'h00010000},  // R4 cap-1 bump
        {24'h000000, 32'h00000031, 24'd0,   32'h00010000}   // single byte, R1
    };

    initial begin
        repeat (4) @(negedge clk);
        // R11: reset state.
        check(!busy && !done, "R11 busy and done low in reset", longint'({busy, done}), 0);
        check(!cart_rd_en && !dram_wr_en, "R11 strobes low in reset", longint'({cart_rd_en, dram_wr_en}), 0);
        check(len_out == 24'h7F, "R11 length reset value", longint'(len_out), 24'h7F);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy, "R11 idle after reset", longint'(busy), 0);

        for (int v = 0; v < 7; v++) begin
            run(VEC[v][111:88], VEC[v][87:56], VEC[v][55:32], VEC[v][31:0], 1'b0);
        end

        // R10: a start pulse while busy is ignored.
        run(24'h000002, 32'h00000200, 24'd260, 32'h00010000, 1'b1);

        // R8: image ends mid-chunk at an odd byte position.
        run(24'h000008, 32'h00000004, 24'd20, 32'h0000000D, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule